// File: doc/BRIEF.md
# Population Fitness State Tracker

This block keeps the health record for a population of alternative implementations of one function. At most two of them run at a time, one on a left slot and one on a right slot. Each comparison of their outputs arrives as one result. The block keeps a discrepancy total, an evaluation count and a health state for each individual. It updates the two active entries on every accepted comparison. When an individual's evaluation window closes, the block applies two programmable thresholds to that individual's discrepancy total.

Each comparison produces registered requests. A swap request tells the loader to rotate an active individual out. A repair request names the one individual that the regeneration logic must work on next. Any index can be read back through a combinational query port, which gives that individual's health state and discrepancy total.

Top module: `fitness_tracker`

## Requirements
- R1: After reset every entry reads health code 0 (Pristine) with a discrepancy total of 0, and swap_left, swap_right and repair_valid are low.
- R2: An accepted comparison with cmp_mismatch low leaves both discrepancy totals and states unchanged, apart from the window rules of R4.
- R3: An accepted comparison with cmp_mismatch high adds one to both discrepancy totals and at once moves any individual in code 0 (Pristine) to code 1 (Suspect).
- R4: Each individual's window closes on its EVAL_WIN-th accepted comparison, which defaults to 10. At that point the state decision is made, and the discrepancy total and evaluation count both return to 0.
- R5: When the window closes, an individual in code 0, 1 or 3 whose total is strictly above thr_repair moves to code 2 (Under Repair).
- R6: When the window closes, an individual in code 2 whose total is strictly below thr_outlier moves to code 3 (Refurbished). Otherwise it stays in code 2.
- R7: A discrepancy total saturates at all ones (7 with DV_W=3) and does not wrap.
- R8: One cycle after an accepted comparison, a side's swap output pulses in three cases: the comparison mismatched, that side's window closed, or the 16-bit LFSR sample is below reintro_prob. The LFSR is seeded with 16'hACE1, shifts left taking in bit15^bit13^bit12^bit10, and advances once per accepted comparison.
- R9: One cycle after a comparison that leaves a closed-window individual in code 2, repair_valid pulses once with repair_idx set to that individual. When both sides qualify, the left one is named.
- R10: A comparison whose left and right indices are equal is ignored. It changes no entry, raises no output and does not advance the LFSR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | A comparison result is present |
| cmp_mismatch | input | 1 | The two active outputs disagreed |
| left_idx | input | IDX_W | Individual on the left slot |
| right_idx | input | IDX_W | Individual on the right slot |
| thr_repair | input | DV_W | Threshold for demotion to Under Repair |
| thr_outlier | input | DV_W | Threshold for promotion to Refurbished |
| reintro_prob | input | 16 | Random rotation probability, scaled to 2^16 |
| query_idx | input | IDX_W | Entry to read back |
| query_state | output | 2 | Health code of the queried entry |
| query_dv | output | DV_W | Discrepancy total of the queried entry |
| swap_left | output | 1 | Rotate the left individual out |
| swap_right | output | 1 | Rotate the right individual out |
| repair_valid | output | 1 | A repair request is present |
| repair_idx | output | IDX_W | Individual to repair |

## Verification
The hardest case to reach from the ports is a window that closes on only one side while the other side's window is still open. The lifecycle round trip is also hard to reach, because code 3 going back to code 2 needs a history of several windows. The stimulus shares one individual across pairings with different partners, so its evaluation count runs out of step with its partners' counts. It drives that individual through the full cycle: mismatch bursts, then clean windows, then mismatch bursts again. A behavioural reference model runs the LFSR itself, so the random rotations are predicted exactly for each comparison.

// File: rtl/ft_pkg.sv
package ft_pkg;
  typedef enum logic [1:0] {
    HS_PRISTINE = 2'd0,
    HS_SUSPECT  = 2'd1,
    HS_REPAIR   = 2'd2,
    HS_REFURB   = 2'd3
  } health_t;

  // One step of the 16-bit rotation generator (x^16+x^14+x^13+x^11).
  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/ft_lfsr.sv
module ft_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  output logic [15:0] sample
);
  import ft_pkg::*;
  logic [15:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   state_q <= SEED;
    else if (adv) state_q <= lfsr_step(state_q);
  end

  assign sample = state_q;
endmodule

// File: rtl/ft_side_update.sv
module ft_side_update #(
  parameter int DV_W     = 3,
  parameter int EVAL_WIN = 10,
  parameter int CNT_W    = 4
) (
  input  ft_pkg::health_t  st_i,
  input  logic [DV_W-1:0]  dv_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             mism_i,
  input  logic [DV_W-1:0]  thr_rep_i,
  input  logic [DV_W-1:0]  thr_out_i,
  output ft_pkg::health_t  st_o,
  output logic [DV_W-1:0]  dv_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o,
  output logic             repair_o
);
  import ft_pkg::*;

  function automatic logic [DV_W-1:0] sat_inc(input logic [DV_W-1:0] v);
    return (v == '1) ? v : v + DV_W'(1);
  endfunction

  health_t          st_mid;
  logic [DV_W-1:0]  dv_acc;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    st_mid  = (mism_i && st_i == HS_PRISTINE) ? HS_SUSPECT : st_i;
    dv_acc  = mism_i ? sat_inc(dv_i) : dv_i;
    cnt_inc = cnt_i + CNT_W'(1);
    done_o  = (cnt_inc == CNT_W'(EVAL_WIN));
    st_o    = st_mid;
    dv_o    = dv_acc;
    cnt_o   = cnt_inc;
    if (done_o) begin
      dv_o  = '0;
      cnt_o = '0;
      if (st_mid != HS_REPAIR && dv_acc > thr_rep_i)      st_o = HS_REPAIR;
      else if (st_mid == HS_REPAIR && dv_acc < thr_out_i) st_o = HS_REFURB;
    end
    repair_o = done_o && (st_o == HS_REPAIR);
  end
endmodule

// File: rtl/fitness_tracker.sv
module fitness_tracker #(
  parameter int          POP      = 16,
  parameter int          DV_W     = 3,
  parameter int          EVAL_WIN = 10,
  parameter logic [15:0] SEED     = 16'hACE1,
  localparam int         IDX_W    = $clog2(POP),
  localparam int         CNT_W    = $clog2(EVAL_WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_valid,
  input  logic             cmp_mismatch,
  input  logic [IDX_W-1:0] left_idx,
  input  logic [IDX_W-1:0] right_idx,
  input  logic [DV_W-1:0]  thr_repair,
  input  logic [DV_W-1:0]  thr_outlier,
  input  logic [15:0]      reintro_prob,
  input  logic [IDX_W-1:0] query_idx,
  output logic [1:0]       query_state,
  output logic [DV_W-1:0]  query_dv,
  output logic             swap_left,
  output logic             swap_right,
  output logic             repair_valid,
  output logic [IDX_W-1:0] repair_idx
);
  import ft_pkg::*;

  health_t          st_q  [POP];
  logic [DV_W-1:0]  dv_q  [POP];
  logic [CNT_W-1:0] cnt_q [POP];

  logic [IDX_W-1:0] idx_s  [2];
  health_t          st_n   [2];
  logic [DV_W-1:0]  dv_n   [2];
  logic [CNT_W-1:0] cnt_n  [2];
  logic             done_s [2];
  logic             rep_s  [2];

  logic        evt_accept, evt_rnd, evt_done_l, evt_done_r;
  logic [15:0] lfsr_val;

  assign idx_s[0]   = left_idx;
  assign idx_s[1]   = right_idx;
  assign evt_accept = cmp_valid && (left_idx != right_idx)
                      && ({1'b0, left_idx}  < (IDX_W+1)'(POP))
                      && ({1'b0, right_idx} < (IDX_W+1)'(POP));
  assign evt_rnd    = lfsr_val < reintro_prob;
  assign evt_done_l = evt_accept && done_s[0];
  assign evt_done_r = evt_accept && done_s[1];

  ft_lfsr #(.SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .adv(evt_accept), .sample(lfsr_val)
  );

  for (genvar s = 0; s < 2; s++) begin : g_side
    ft_side_update #(.DV_W(DV_W), .EVAL_WIN(EVAL_WIN), .CNT_W(CNT_W)) u_upd (
      .st_i(st_q[idx_s[s]]), .dv_i(dv_q[idx_s[s]]), .cnt_i(cnt_q[idx_s[s]]),
      .mism_i(cmp_mismatch), .thr_rep_i(thr_repair), .thr_out_i(thr_outlier),
      .st_o(st_n[s]), .dv_o(dv_n[s]), .cnt_o(cnt_n[s]),
      .done_o(done_s[s]), .repair_o(rep_s[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < POP; k++) begin
        st_q[k]  <= HS_PRISTINE;
        dv_q[k]  <= '0;
        cnt_q[k] <= '0;
      end
    end else if (evt_accept) begin
      for (int k = 0; k < POP; k++) begin
        if (idx_s[0] == IDX_W'(k)) begin
          st_q[k] <= st_n[0]; dv_q[k] <= dv_n[0]; cnt_q[k] <= cnt_n[0];
        end else if (idx_s[1] == IDX_W'(k)) begin
          st_q[k] <= st_n[1]; dv_q[k] <= dv_n[1]; cnt_q[k] <= cnt_n[1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      swap_left    <= 1'b0;
      swap_right   <= 1'b0;
      repair_valid <= 1'b0;
      repair_idx   <= '0;
    end else begin
      swap_left    <= evt_accept && (cmp_mismatch || done_s[0] || evt_rnd);
      swap_right   <= evt_accept && (cmp_mismatch || done_s[1] || evt_rnd);
      repair_valid <= evt_accept && (rep_s[0] || rep_s[1]);
      repair_idx   <= !evt_accept ? '0 : (rep_s[0] ? left_idx : (rep_s[1] ? right_idx : '0));
    end
  end

  assign query_state = st_q[query_idx];
  assign query_dv    = dv_q[query_idx];
endmodule

// File: rtl/ft_checker.sv
module ft_checker #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmp_valid,
  input logic             cmp_mismatch,
  input logic [IDX_W-1:0] left_idx,
  input logic [IDX_W-1:0] right_idx,
  input logic             swap_left,
  input logic             swap_right,
  input logic             repair_valid,
  input logic [IDX_W-1:0] repair_idx,
  input logic             evt_accept,
  input logic             evt_done_l,
  input logic             evt_done_r
);
  p_mismatch_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept && cmp_mismatch |=> swap_left && swap_right);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_accept |=> !swap_left && !swap_right && !repair_valid);

  p_same_idx_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && (left_idx == right_idx) |=> !swap_left && !swap_right && !repair_valid);

  p_window_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done_l |=> swap_left);

  p_repair_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept && !evt_done_l && !evt_done_r |=> !repair_valid);

  p_repair_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> !repair_valid || repair_idx == $past(left_idx) || repair_idx == $past(right_idx));
endmodule

bind fitness_tracker ft_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_mismatch(cmp_mismatch),
  .left_idx(left_idx), .right_idx(right_idx), .swap_left(swap_left),
  .swap_right(swap_right), .repair_valid(repair_valid), .repair_idx(repair_idx),
  .evt_accept(evt_accept), .evt_done_l(evt_done_l), .evt_done_r(evt_done_r)
);

// File: tb/tb_fitness_tracker.sv
module tb_fitness_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int POP = 16;
  localparam int DV_W = 3;
  localparam int EVAL = 10;
  localparam int DV_MAX = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmp_valid = 1'b0, cmp_mismatch = 1'b0;
  logic [3:0] left_idx = '0, right_idx = '0, query_idx = '0, repair_idx;
  logic [DV_W-1:0] thr_repair = 3'd3, thr_outlier = 3'd2, query_dv;
  logic [15:0] reintro_prob = 16'd0;
  logic [1:0] query_state;
  logic swap_left, swap_right, repair_valid;

  int checks = 0, failures = 0;
  int m_st[POP], m_dv[POP], m_cnt[POP];
  logic [15:0] m_lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  fitness_tracker dut (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic query(string req, int i);
    query_idx = i[3:0];
    #1;
    chk(req, $sformatf("state[%0d]", i), int'(query_state), m_st[i]);
    chk(req, $sformatf("dv[%0d]", i), int'(query_dv), m_dv[i]);
  endtask

  // Reference model of one side of an accepted comparison.
  task automatic model_side(int i, bit mm, output bit done, output bit rep);
    int st = m_st[i], dv = m_dv[i], c = m_cnt[i] + 1;
    if (mm) begin
      dv = (dv == DV_MAX) ? dv : dv + 1;
      if (st == 0) st = 1;
    end
    done = (c == EVAL);
    if (done) begin
      if (st != 2 && dv > int'(thr_repair)) st = 2;
      else if (st == 2 && dv < int'(thr_outlier)) st = 3;
      dv = 0; c = 0;
    end
    rep = done && st == 2;
    m_st[i] = st; m_dv[i] = dv; m_cnt[i] = c;
  endtask

  task automatic step(string req, int l, int r, bit mm);
    bit dl = 0, dr = 0, rl = 0, rr = 0, rnd = 0, acc;
    @(negedge clk);
    cmp_valid = 1'b1; cmp_mismatch = mm; left_idx = l[3:0]; right_idx = r[3:0];
    acc = (l != r);
    if (acc) begin
      rnd = m_lfsr < reintro_prob;
      model_side(l, mm, dl, rl);
      model_side(r, mm, dr, rr);
      m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end
    @(negedge clk);
    cmp_valid = 1'b0;
    chk({req, "/R8"}, "swap_left", int'(swap_left), int'(acc && (mm || dl || rnd)));
    chk({req, "/R8"}, "swap_right", int'(swap_right), int'(acc && (mm || dr || rnd)));
    chk({req, "/R9"}, "repair_valid", int'(repair_valid), int'(rl || rr));
    if (rl || rr) chk({req, "/R9"}, "repair_idx", int'(repair_idx), rl ? l : r);
    query(req, l);
    if (acc) query(req, r);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < POP; k++) begin m_st[k] = 0; m_dv[k] = 0; m_cnt[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "swap_left", int'(swap_left), 0);
    chk("R1", "swap_right", int'(swap_right), 0);
    chk("R1", "repair_valid", int'(repair_valid), 0);
    for (int k = 0; k < POP; k++) query("R1", k);

    // R2/R4: clean window for 0 and 1
    for (int n = 0; n < EVAL; n++) step("R2_R4", 0, 1, 1'b0);
    // R3/R7/R5: mismatch burst saturates totals, both go to repair, left named
    for (int n = 0; n < EVAL; n++) step("R3_R7_R5", 2, 3, 1'b1);
    // R10: equal indices ignored
    step("R10", 5, 5, 1'b1);
    query("R10", 5);
    // R6: repair individual with a clean window becomes refurbished
    for (int n = 0; n < EVAL; n++) step("R6", 2, 4, 1'b0);
    // Suspect with low total stays suspect
    step("R3", 6, 7, 1'b1);
    for (int n = 1; n < EVAL; n++) step("R5", 6, 7, 1'b0);
    // Refurbished back to repair; both qualify, left priority
    for (int n = 0; n < EVAL; n++) step("R5_R9", 2, 8, n < 4);
    // Right-only window close with repair
    for (int n = 0; n < 5; n++) step("R9", 12, 11, 1'b1);
    for (int n = 0; n < 5; n++) step("R9", 13, 11, 1'b0);
    // Random rotation
    reintro_prob = 16'hFFFF;
    for (int n = 0; n < 6; n++) step("R8", 14, 15, 1'b0);
    reintro_prob = 16'h8000;
    for (int n = 0; n < 24; n++) step("R8", n % 5 + 9, 15, n % 7 == 0);
    step("R10", 9, 9, 1'b0);
    step("R8", 9, 10, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule